// File: doc/BRIEF.md
# Framed 24-bit Serial Command Receiver

This block takes command words from a three-wire serial link: an active-low frame select, a serial clock and a serial data line. All three inputs are oversampled by a faster system clock. Each input passes through a synchronizer. The block then looks for serial-clock falling edges inside an open frame and shifts the data line in, most significant bit first.

When the twenty-fourth bit arrives, the block raises a one-cycle strobe. During that strobe it presents the upper eight bits as a control byte and the lower sixteen bits as a data word. It does not wait for the frame select to return high.

After the strobe, the receiver locks and ignores further serial-clock edges until the select line rises and falls again. A frame that is cut short by the select line rising is dropped without a trace. The downstream command decoder only ever sees whole words.

Top module: `cmd_frame_rx`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `word_valid_o` is 0 and `ctrl_o` and `data_o` are 0.
- R2: A data bit is taken on each falling edge of `ser_clk_i` while `frame_n_i` is low, first bit into bit 23. Word bits 23..16 appear on `ctrl_o` and bits 15..0 appear on `data_o`.
- R3: The 24th falling edge of a frame releases exactly one word, with `frame_n_i` still low.
- R4: `word_valid_o` is high for exactly one system clock cycle per word. `ctrl_o` and `data_o` carry the word during that cycle and keep it until the next release.
- R5: Serial-clock edges after the 24th in the same frame cause no further release and leave the outputs unchanged.
- R6: If `frame_n_i` rises before the 24th falling edge, no word is released and the outputs keep the previous word. The next frame starts from an empty shift register.
- R7: After a completed frame with `frame_n_i` held low, a further 24 falling edges release nothing. A new frame needs a fresh falling edge of `frame_n_i`.
- R8: Serial-clock edges while `frame_n_i` is high are ignored and do not enter the next frame.
- R9: Each input passes two synchronizer flops. `word_valid_o` is high in the cycle after the third rising system clock edge that follows the 24th serial-clock fall, and low before it. The system clock must run at least four times faster than `ser_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rst | input | 1 | Synchronous active-high reset |
| frame_n_i | input | 1 | Frame select, active low |
| ser_clk_i | input | 1 | Serial clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| word_valid_o | output | 1 | One-cycle strobe marking a complete word |
| ctrl_o | output | 8 | Upper eight bits of the released word |
| data_o | output | 16 | Lower sixteen bits of the released word |

## Verification
The bench aims at frame boundaries.

- Frames cut short at 10 and at 23 bits: a counter that fires one bit early would release on the 23-bit abort.
- Frames overrun to 30 clocks: a receiver that keeps shifting after the lock would release a second word or corrupt the outputs.
- A second 24-bit burst with the select held low: this catches a design that re-arms on its counter instead of on a fresh select edge.
- Clocks sent while the select is high: this exposes shift-register contents leaking into the following frame.
- A cycle-exact probe of the strobe: this catches a missing or extra synchronizer stage, and a strobe wider than one cycle.

// File: rtl/cmd_rx_pkg.sv
package cmd_rx_pkg;

  localparam int unsigned FRAME_BITS_DEF  = 24;
  localparam int unsigned CTRL_BITS_DEF   = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  // Width of a counter that must reach n inclusive.
  function automatic int unsigned cnt_width(input int unsigned n);
    return $clog2(n + 1);
  endfunction

  // True when the bit about to be taken completes the frame.
  function automatic logic frame_done(input int unsigned taken_after, input int unsigned total);
    return taken_after == total;
  endfunction

endpackage

// File: rtl/cmd_rx_sync.sv
module cmd_rx_sync #(
  parameter int unsigned     WIDTH   = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < int'(STAGES); s++) chain_q[s] <= RST_VAL;
    end else begin
      chain_q[0] <= d_in;
      for (int s = 1; s < int'(STAGES); s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/cmd_rx_edge.sv
module cmd_rx_edge #(
  parameter int unsigned      WIDTH   = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] fall,
  output logic [WIDTH-1:0] rise
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= level;
  end

  for (genvar b = 0; b < int'(WIDTH); b++) begin : g_bit
    assign fall[b] = prev_q[b] & ~level[b];
    assign rise[b] = ~prev_q[b] & level[b];
  end

endmodule

// File: rtl/cmd_rx_shift.sv
module cmd_rx_shift
  import cmd_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS = FRAME_BITS_DEF,
  parameter int unsigned CTRL_BITS  = CTRL_BITS_DEF
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             sel_low,
  input  logic                             sel_fall,
  input  logic                             sel_rise,
  input  logic                             bit_strobe,
  input  logic                             bit_val,
  output logic                             word_valid,
  output logic [CTRL_BITS-1:0]             ctrl_out,
  output logic [FRAME_BITS-CTRL_BITS-1:0]  data_out
);

  localparam int unsigned DATA_BITS = FRAME_BITS - CTRL_BITS;
  localparam int unsigned CNT_W     = cnt_width(FRAME_BITS);

  logic                  armed_q;
  logic                  locked_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [FRAME_BITS-1:0] sh_q;
  logic [CTRL_BITS-1:0]  ctrl_q;
  logic [DATA_BITS-1:0]  data_q;
  logic                  valid_q;

  // Named internal events, visible to the assertions below.
  logic                  take_bit;
  logic                  last_bit;
  logic [FRAME_BITS-1:0] next_sh;

  assign take_bit = armed_q & ~locked_q & sel_low & bit_strobe & ~sel_fall & ~sel_rise;
  assign last_bit = frame_done(32'(cnt_q) + 32'd1, FRAME_BITS);
  assign next_sh  = {sh_q[FRAME_BITS-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q  <= 1'b0;
      locked_q <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
      ctrl_q   <= '0;
      data_q   <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (sel_rise) begin
        armed_q  <= 1'b0;
        locked_q <= 1'b0;
        cnt_q    <= '0;
        sh_q     <= '0;
      end else if (sel_fall) begin
        armed_q  <= 1'b1;
        locked_q <= 1'b0;
        cnt_q    <= '0;
        sh_q     <= '0;
      end else if (take_bit) begin
        sh_q  <= next_sh;
        cnt_q <= cnt_q + 1'b1;
        if (last_bit) begin
          locked_q <= 1'b1;
          valid_q  <= 1'b1;
          ctrl_q   <= next_sh[FRAME_BITS-1 -: CTRL_BITS];
          data_q   <= next_sh[DATA_BITS-1:0];
        end
      end
    end
  end

  assign word_valid = valid_q;
  assign ctrl_out   = ctrl_q;
  assign data_out   = data_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(FRAME_BITS));

  // R2
  word_match_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> ({ctrl_q, data_q} == sh_q));

  // R3
  lock_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_q) |-> valid_q);

  // R4
  valid_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !sel_rise && !sel_fall) |=> (locked_q && $stable(sh_q)));

  // R6
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sel_rise |=> (cnt_q == '0 && !locked_q && !armed_q));

  // R8
  idle_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel_low && !sel_rise) |-> (cnt_q == '0));

endmodule

// File: rtl/cmd_frame_rx.sv
module cmd_frame_rx
  import cmd_rx_pkg::*;
#(
  parameter int unsigned FRAME_BITS  = FRAME_BITS_DEF,
  parameter int unsigned CTRL_BITS   = CTRL_BITS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            frame_n_i,
  input  logic                            ser_clk_i,
  input  logic                            ser_dat_i,
  output logic                            word_valid_o,
  output logic [CTRL_BITS-1:0]            ctrl_o,
  output logic [FRAME_BITS-CTRL_BITS-1:0] data_o
);

  // Vector order: [2] frame select, [1] serial clock, [0] serial data.
  localparam logic [2:0] SYNC_RST = 3'b100;
  localparam logic [1:0] EDGE_RST = 2'b10;

  logic [2:0] pins_s;
  logic [1:0] fall_v;
  logic [1:0] rise_v;
  logic       unused_clk_rise;

  cmd_rx_sync #(
    .WIDTH   (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({frame_n_i, ser_clk_i, ser_dat_i}),
    .d_out (pins_s)
  );

  cmd_rx_edge #(
    .WIDTH   (2),
    .RST_VAL (EDGE_RST)
  ) u_edge (
    .clk   (clk),
    .rst   (rst),
    .level (pins_s[2:1]),
    .fall  (fall_v),
    .rise  (rise_v)
  );

  assign unused_clk_rise = rise_v[0];

  cmd_rx_shift #(
    .FRAME_BITS (FRAME_BITS),
    .CTRL_BITS  (CTRL_BITS)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .sel_low    (~pins_s[2]),
    .sel_fall   (fall_v[1]),
    .sel_rise   (rise_v[1]),
    .bit_strobe (fall_v[0]),
    .bit_val    (pins_s[0]),
    .word_valid (word_valid_o),
    .ctrl_out   (ctrl_o),
    .data_out   (data_o)
  );

endmodule

// File: tb/cmd_frame_rx_test.sv
module cmd_frame_rx_test;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int N_VEC      = 8;

  // {clock count [29:24], word [23:0]}; count >= 24 means one release expected.
  localparam logic [29:0] VEC [N_VEC] = '{
    {6'd24, 24'hA51234},
    {6'd24, 24'h000000},
    {6'd24, 24'hFFFFFF},
    {6'd10, 24'h3C0F0F},
    {6'd24, 24'h018001},
    {6'd30, 24'h5AC3A5},
    {6'd23, 24'h123456},
    {6'd24, 24'h800001}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_n_i = 1'b1;
  logic        ser_clk_i = 1'b0;
  logic        ser_dat_i = 1'b0;
  logic        word_valid_o;
  logic [7:0]  ctrl_o;
  logic [15:0] data_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  int wide   = 0;
  logic prev_v = 1'b0;

  cmd_frame_rx uut (
    .clk          (clk),
    .rst          (rst),
    .frame_n_i    (frame_n_i),
    .ser_clk_i    (ser_clk_i),
    .ser_dat_i    (ser_dat_i),
    .word_valid_o (word_valid_o),
    .ctrl_o       (ctrl_o),
    .data_o       (data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (word_valid_o) begin
        pulses = pulses + 1;
        if (prev_v) wide = wide + 1;
      end
      prev_v = word_valid_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bits past the 24th are driven as the complement of the frame's leading bits.
  task automatic shift_bits(input logic [23:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      ser_dat_i = (i < 24) ? w[23-i] : ~w[23-(i-24)];
      ser_clk_i = 1'b1;
      tick(HALF);
      ser_clk_i = 1'b0;
      if (i != n-1) tick(HALF);
    end
  endtask

  task automatic open_frame();
    frame_n_i = 1'b0;
    tick(HALF);
  endtask

  task automatic close_frame();
    frame_n_i = 1'b1;
    tick(8);
  endtask

  function automatic logic [31:0] outw();
    return {8'h00, ctrl_o, data_o};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [23:0] last_word;
    int          p0;

    // R1: reset state, during reset and in the first cycle after it
    tick(3);
    check("R1 valid in reset", {31'd0, word_valid_o}, 32'd0);
    check("R1 word in reset", outw(), 32'd0);
    rst = 1'b0;
    tick(1);
    check("R1 valid after reset", {31'd0, word_valid_o}, 32'd0);
    check("R1 word after reset", outw(), 32'd0);
    tick(4);

    // Table of frames: R2 data, R3 release, R5 overrun, R6 aborts
    last_word = 24'h0;
    for (int v = 0; v < N_VEC; v++) begin
      logic [23:0] w;
      int          n;
      w  = VEC[v][23:0];
      n  = int'(VEC[v][29:24]);
      p0 = pulses;
      open_frame();
      shift_bits(w, n);
      tick(8);
      if (n >= 24) begin
        check("R3 one release, select low", 32'(pulses - p0), 32'd1);
        check("R2 word content", outw(), {8'h00, w});
        last_word = w;
      end else begin
        check("R6 aborted frame no release", 32'(pulses - p0), 32'd0);
      end
      close_frame();
      if (n > 24)
        check("R5 extra clocks ignored", {8'h00, outw()[23:0]}, {8'h00, last_word});
      check("R6 outputs hold last word", outw(), {8'h00, last_word});
    end

    // R9: strobe timing through the synchronizers; R4 single cycle
    open_frame();
    shift_bits(24'hC0FFEE, 24);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R9 no strobe after two edges", {31'd0, word_valid_o}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 strobe after third edge", {31'd0, word_valid_o}, 32'd1);
    check("R4 word during strobe", outw(), 32'h00C0FFEE);
    @(negedge clk);
    check("R4 strobe drops after one cycle", {31'd0, word_valid_o}, 32'd0);
    check("R4 word held after strobe", outw(), 32'h00C0FFEE);

    // R7: select kept low, a second burst releases nothing
    tick(8);
    p0 = pulses;
    shift_bits(24'h13579B, 24);
    tick(8);
    check("R7 no release without fresh select", 32'(pulses - p0), 32'd0);
    check("R7 outputs unchanged", outw(), 32'h00C0FFEE);
    close_frame();

    // R8: clocks with select high are ignored and do not leak
    p0 = pulses;
    shift_bits(24'hFFFFFF, 24);
    tick(8);
    check("R8 no release while deselected", 32'(pulses - p0), 32'd0);
    open_frame();
    shift_bits(24'h2468AC, 24);
    tick(8);
    check("R8 next frame clean", outw(), 32'h002468AC);
    close_frame();

    // R4: no strobe ever lasted more than one cycle
    check("R4 strobe width", 32'(wide), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule